// File: doc/BRIEF.md
# Vectored Two-Class Interrupt Controller

This block gathers up to 64 level-sensitive interrupt lines and sorts them into two classes: a fast class and a normal class, each with its own request output. Every channel carries a three-bit priority level that both ranks it and picks its class. For each class the hardware finds the best pending, enabled channel and keeps a ready-made handler address for it. A handler reads that address and jumps to it directly, with no software scan of pending bits.

Software reaches the block through a simple word-addressed register port. Through it, software sets per-channel enable bits, per-channel priority fields and the base address of the handler table. It can read and clear the sticky pending bits and read the two entry registers. Edge detection, synchronization of external pins and the processor itself sit outside this block.

Top module: `vec_intc`

## Requirements
- R1: After reset both request outputs are low, every enable bit is 0, every priority field reads 7, the table base reads 0 and both entry registers read 0.
- R2: A channel whose source is high at a clock edge has its pending bit set at that edge. The bit stays set after the source falls, whatever the channel's enable. Pending bits for channels 0..31 are read at word address 2 and for channels 32..63 at address 3, with bit n of the word holding channel n modulo 32.
- R3: Writing a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. If the channel's source is high in the same cycle, the bit stays set.
- R4: Enable bits sit at word address 0 (channels 0..31) and 1 (channels 32..63). A channel whose enable bit is 0 never raises an output and never wins.
- R5: Priority fields are 4 bits wide, eight per word, starting at word address 8. Channel c uses word 8 + c/8 at bits 4*(c%8)+2 down to 4*(c%8). The upper bit of each field reads 0. Levels 0 and 1 form the fast class and levels 2 to 7 form the normal class.
- R6: Within a class, the numerically lowest level wins. Among channels at the same level, the lowest channel number wins.
- R7: The table base is written at word address 4. The fast entry reads at address 5 and the normal entry at address 6. An entry holds base + 4 x winning channel, or the base itself when its class has no winner.
- R8: The fast output (fast_req) is high exactly when a pending, enabled, fast-class channel exists. The normal output (norm_req) is high exactly when a pending, enabled, normal-class channel exists.
- R9: Outputs and entries change one clock after the pending, enable, priority or base state changes. A source sampled high at one edge therefore shows at the outputs after the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_CH | Level-sensitive interrupt sources, one per channel |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fast_req | output | 1 | Fast-class interrupt request |
| norm_req | output | 1 | Normal-class interrupt request |

## Verification
Two activities can land in the same cycle. One is a write-one-to-clear on a pending bit. The other is that channel's source being sampled high, which sets the same bit. The bench holds a source high, writes a 1 to its pending bit, and expects the bit to read back as still set with the fast output still high. A second collision pairs an enable write that masks a pending winner with the registered output stage. The output must stay high for exactly one more cycle and then fall, and the entry must return to the base.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 5;
  localparam int unsigned PW       = 3;
  localparam int unsigned FW       = 4;
  localparam int unsigned LEVELS   = 8;
  localparam int unsigned FAST_TOP = 1;

  localparam int unsigned A_ENA  = 0;
  localparam int unsigned A_STS  = 2;
  localparam int unsigned A_BASE = 4;
  localparam int unsigned A_FENT = 5;
  localparam int unsigned A_NENT = 6;
  localparam int unsigned A_PRIO = 8;

  localparam logic [PW-1:0] PRIO_RST = PW'(LEVELS - 1);

  typedef logic [DW-1:0] word_t;

  // Handler address of a channel: table base plus four bytes per channel.
  function automatic word_t entry_addr(word_t base, word_t idx);
    return base + (idx << 2);
  endfunction

  // Sticky pending bit: a set from the source dominates a clear in the same cycle.
  function automatic logic sts_next(logic cur, logic src, logic clr);
    return src | (cur & ~clr);
  endfunction
endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          irq_src,
  input  logic                       bus_wr,
  input  logic [AW-1:0]              bus_addr,
  input  word_t                      bus_wdata,
  output word_t                      bus_rdata,
  input  word_t                      fast_entry,
  input  word_t                      norm_entry,
  output logic [NUM_CH-1:0]          ena_q,
  output logic [NUM_CH-1:0]          sts_q,
  output logic [NUM_CH-1:0][PW-1:0]  prio_q,
  output word_t                      base_q
);
  localparam int unsigned NW     = (NUM_CH + DW - 1) / DW;
  localparam int unsigned SLOTS  = DW / FW;
  localparam int unsigned PWORDS = (NUM_CH + SLOTS - 1) / SLOTS;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned WI = ch / DW;
    localparam int unsigned BI = ch % DW;
    localparam int unsigned PI = ch / SLOTS;
    localparam int unsigned FI = (ch % SLOTS) * FW;

    logic          ena_hit;
    logic          sts_clr;
    logic          prio_hit;
    logic          ena_r;
    logic          sts_r;
    logic [PW-1:0] prio_r;

    assign ena_hit  = bus_wr && (bus_addr == AW'(A_ENA + WI));
    assign sts_clr  = bus_wr && (bus_addr == AW'(A_STS + WI)) && bus_wdata[BI];
    assign prio_hit = bus_wr && (bus_addr == AW'(A_PRIO + PI));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ena_r  <= 1'b0;
        sts_r  <= 1'b0;
        prio_r <= PRIO_RST;
      end else begin
        if (ena_hit)  ena_r  <= bus_wdata[BI];
        if (prio_hit) prio_r <= bus_wdata[FI +: PW];
        sts_r <= sts_next(sts_r, irq_src[ch], sts_clr);
      end
    end

    assign ena_q[ch]  = ena_r;
    assign sts_q[ch]  = sts_r;
    assign prio_q[ch] = prio_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  base_q <= '0;
    else if (bus_wr && bus_addr == AW'(A_BASE))  base_q <= bus_wdata;
  end

  logic [NW*DW-1:0]     ena_pad;
  logic [NW*DW-1:0]     sts_pad;
  logic [PWORDS*DW-1:0] prio_pad;

  always_comb begin
    ena_pad  = '0;
    sts_pad  = '0;
    prio_pad = '0;
    ena_pad[NUM_CH-1:0] = ena_q;
    sts_pad[NUM_CH-1:0] = sts_q;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      prio_pad[ch*FW +: PW] = prio_q[ch];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (bus_addr == AW'(A_ENA + w)) bus_rdata = ena_pad[w*DW +: DW];
      if (bus_addr == AW'(A_STS + w)) bus_rdata = sts_pad[w*DW +: DW];
    end
    for (int p = 0; p < PWORDS; p++) begin
      if (bus_addr == AW'(A_PRIO + p)) bus_rdata = prio_pad[p*DW +: DW];
    end
    if (bus_addr == AW'(A_BASE)) bus_rdata = base_q;
    if (bus_addr == AW'(A_FENT)) bus_rdata = fast_entry;
    if (bus_addr == AW'(A_NENT)) bus_rdata = norm_entry;
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned LO     = 0,
  parameter int unsigned HI     = 1,
  parameter int unsigned IW     = 6
) (
  input  logic [NUM_CH-1:0]          req,
  input  logic [NUM_CH-1:0][PW-1:0]  prio_q,
  output logic                       hit,
  output logic [IW-1:0]              idx
);
  localparam int unsigned NL = HI - LO + 1;

  logic [NL-1:0][NUM_CH-1:0] lvl_mask;
  logic [NUM_CH-1:0]         sel;

  // One request mask per priority level of this class.
  for (genvar l = 0; l < NL; l++) begin : g_lvl
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign lvl_mask[l][ch] = req[ch] && (prio_q[ch] == PW'(LO + l));
    end
  end

  // Best level first, then lowest channel within it.
  always_comb begin
    sel = '0;
    for (int l = NL - 1; l >= 0; l--) begin
      if (|lvl_mask[l]) sel = lvl_mask[l];
    end
    idx = '0;
    for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
      if (sel[ch]) idx = IW'(ch);
    end
    hit = |sel;
  end
endmodule

// File: rtl/vic_class_unit.sv
module vic_class_unit
  import vic_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned LO     = 0,
  parameter int unsigned HI     = 1,
  parameter int unsigned IW     = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          req,
  input  logic [NUM_CH-1:0][PW-1:0]  prio_q,
  input  word_t                      base_q,
  output logic                       active_q,
  output word_t                      entry_q,
  output logic                       win_hit,
  output logic [IW-1:0]              win_idx
);
  vic_arbiter #(
    .NUM_CH (NUM_CH),
    .LO     (LO),
    .HI     (HI),
    .IW     (IW)
  ) u_arb (
    .req    (req),
    .prio_q (prio_q),
    .hit    (win_hit),
    .idx    (win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      entry_q  <= '0;
    end else begin
      active_q <= win_hit;
      entry_q  <= win_hit ? entry_addr(base_q, word_t'(win_idx)) : base_q;
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_src,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              fast_req,
  output logic              norm_req
);
  localparam int unsigned IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned NCLS = 2;

  logic [NUM_CH-1:0]         ena_q;
  logic [NUM_CH-1:0]         sts_q;
  logic [NUM_CH-1:0][PW-1:0] prio_q;
  word_t                     base_q;
  logic [NUM_CH-1:0]         req_vec;
  logic [NCLS-1:0]           cls_active;
  word_t                     cls_entry [NCLS];
  logic [NCLS-1:0]           cls_hit;
  logic [IW-1:0]             cls_idx   [NCLS];
  word_t                     fast_entry;
  word_t                     norm_entry;

  vic_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_src    (irq_src),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .fast_entry (fast_entry),
    .norm_entry (norm_entry),
    .ena_q      (ena_q),
    .sts_q      (sts_q),
    .prio_q     (prio_q),
    .base_q     (base_q)
  );

  assign req_vec = sts_q & ena_q;

  // Class 0 takes the fast levels, class 1 the normal ones.
  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    localparam int unsigned LO = (k == 0) ? 0 : FAST_TOP + 1;
    localparam int unsigned HI = (k == 0) ? FAST_TOP : LEVELS - 1;
    vic_class_unit #(
      .NUM_CH (NUM_CH),
      .LO     (LO),
      .HI     (HI),
      .IW     (IW)
    ) u_cls (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_vec),
      .prio_q   (prio_q),
      .base_q   (base_q),
      .active_q (cls_active[k]),
      .entry_q  (cls_entry[k]),
      .win_hit  (cls_hit[k]),
      .win_idx  (cls_idx[k])
    );
  end

  assign fast_entry = cls_entry[0];
  assign norm_entry = cls_entry[1];
  assign fast_req   = cls_active[0];
  assign norm_req   = cls_active[1];
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
  import vic_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] irq_src,
  input logic              bus_wr,
  input logic [4:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NUM_CH-1:0] sts_q,
  input logic [NUM_CH-1:0] ena_q,
  input logic [31:0]       base_q,
  input logic              fast_req,
  input logic              norm_req,
  input logic [31:0]       fast_entry,
  input logic [31:0]       norm_entry
);
  logic [63:0] sts_pad;
  logic [63:0] src_pad;
  logic [31:0] clr_lo;

  always_comb begin
    sts_pad = '0;
    src_pad = '0;
    sts_pad[NUM_CH-1:0] = sts_q;
    src_pad[NUM_CH-1:0] = irq_src;
  end
  assign clr_lo = bus_wdata & ~src_pad[31:0];

  assert_sts_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src != '0) |=> ((sts_q & $past(irq_src)) == $past(irq_src)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'(A_STS)) |=> ((sts_pad[31:0] & $past(clr_lo)) == '0));

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ena_q) == '0) |=> (!fast_req && !norm_req));

  assert_req_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_req || norm_req) |-> $past((sts_q & ena_q) != '0));

  assert_idle_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_req && $stable(base_q)) |-> (fast_entry == base_q));

  assert_entry_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_req && $stable(base_q)) |->
      (((norm_entry - base_q) >> 2) < NUM_CH && (norm_entry - base_q) % 4 == 0));
endmodule

bind vec_intc vec_intc_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_src    (irq_src),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .sts_q      (sts_q),
  .ena_q      (ena_q),
  .base_q     (base_q),
  .fast_req   (fast_req),
  .norm_req   (norm_req),
  .fast_entry (fast_entry),
  .norm_entry (norm_entry)
);

// File: tb/tb_vec_intc.sv
module tb_vec_intc;
  localparam int NV = 12;
  localparam logic [31:0] BASE = 32'h0000_4000;

  localparam logic [63:0] VSRC [NV] = '{
    64'h0, 64'h8, 64'h28, 64'h400,
    64'h0000_0100_0000_0400, 64'h0000_0002_0010_0000,
    64'h8000_0000_0000_0080, 64'h8000_0000_0000_0001,
    64'h8000_0000_0010_0020, 64'h0000_0100_0000_0008,
    64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF };
  localparam bit VFON [NV] = '{0,1,1,0,1,0,0,0,1,1,0,1};
  localparam int VFCH [NV] = '{0,3,5,0,40,0,0,0,5,3,0,5};
  localparam bit VNON [NV] = '{0,0,0,0,0,1,1,1,1,0,1,1};
  localparam int VNCH [NV] = '{0,0,0,0,0,20,7,0,20,0,63,20};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_src = '0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fast_req;
  logic        norm_req;

  int nchk = 0;
  int nbad = 0;
  logic [31:0] prio_w [8];

  always #5 clk = ~clk;

  vec_intc #(.NUM_CH(64)) dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fast_req(fast_req), .norm_req(norm_req));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic clear_all();
    irq_src = '0;
    wr(5'd2, 32'hFFFF_FFFF);
    wr(5'd3, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 fast_req", 32'(fast_req), 0);
    chk("R1 norm_req", 32'(norm_req), 0);
    rd(5'd0, r); chk("R1 enable word", r, 0);
    rd(5'd8, r); chk("R1 priority word", r, 32'h7777_7777);
    rd(5'd4, r); chk("R1 base", r, 0);
    rd(5'd5, r); chk("R1 fast entry", r, 0);
    rd(5'd6, r); chk("R1 normal entry", r, 0);

    // Program priorities, enables (channel 10 masked) and base
    for (int w = 0; w < 8; w++) prio_w[w] = 32'h7777_7777;
    prio_w[0][4*5 +: 4] = 4'd0;
    prio_w[1][4*2 +: 4] = 4'd0;
    prio_w[0][4*3 +: 4] = 4'd1;
    prio_w[5][4*0 +: 4] = 4'd1;
    prio_w[2][4*4 +: 4] = 4'd2;
    prio_w[4][4*1 +: 4] = 4'd2;
    prio_w[0][4*7 +: 4] = 4'd4;
    for (int w = 0; w < 8; w++) wr(5'(8 + w), prio_w[w]);
    wr(5'd0, 32'hFFFF_FBFF);
    wr(5'd1, 32'hFFFF_FFFF);
    wr(5'd4, BASE);
    rd(5'd8, r); chk("R5 priority readback", r, 32'h4707_1777);

    // Vector table: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      clear_all();
      irq_src = VSRC[v];
      repeat (3) @(negedge clk);
      chk($sformatf("R8 fast_req vec%0d", v), 32'(fast_req), 32'(VFON[v]));
      chk($sformatf("R8 norm_req vec%0d", v), 32'(norm_req), 32'(VNON[v]));
      rd(5'd5, r);
      chk($sformatf("R6 R7 fast entry vec%0d", v), r,
          VFON[v] ? BASE + 32'(VFCH[v]) * 4 : BASE);
      rd(5'd6, r);
      chk($sformatf("R6 R7 normal entry vec%0d", v), r,
          VNON[v] ? BASE + 32'(VNCH[v]) * 4 : BASE);
    end

    // R9 latency: pending at first edge, output after second
    clear_all();
    irq_src = 64'h8;
    @(negedge clk);
    rd(5'd2, r); chk("R2 pending captured", r, 32'h8);
    chk("R9 output not yet", 32'(fast_req), 0);
    @(negedge clk);
    chk("R9 output after one more edge", 32'(fast_req), 1);

    // R3 clear collides with a source still high
    wr(5'd2, 32'h8);
    rd(5'd2, r); chk("R3 set wins over clear", r, 32'h8);
    chk("R3 request kept", 32'(fast_req), 1);

    // R2 sticky after source falls
    irq_src = '0;
    repeat (2) @(negedge clk);
    rd(5'd2, r); chk("R2 sticky pending", r, 32'h8);
    chk("R2 request held", 32'(fast_req), 1);

    // R3 only bits written as 1 clear
    irq_src = 64'h28;
    @(negedge clk);
    irq_src = '0;
    wr(5'd2, 32'h20);
    rd(5'd2, r); chk("R3 zero bits untouched", r, 32'h8);
    wr(5'd2, 32'h8);
    rd(5'd2, r); chk("R3 cleared", r, 0);
    @(negedge clk);
    chk("R8 request drops", 32'(fast_req), 0);

    // R4 R9 masking a pending winner
    irq_src = 64'h20;
    repeat (3) @(negedge clk);
    rd(5'd5, r); chk("R7 entry ch5", r, BASE + 32'd20);
    wr(5'd0, 32'hFFFF_FBDF);
    chk("R9 one cycle after mask", 32'(fast_req), 1);
    @(negedge clk);
    chk("R4 masked request low", 32'(fast_req), 0);
    rd(5'd5, r); chk("R4 R7 entry back to base", r, BASE);
    rd(5'd2, r); chk("R2 masked still pending", r, 32'h20);
    wr(5'd0, 32'hFFFF_FBFF);
    clear_all();

    // R7 base change with nothing pending
    wr(5'd4, 32'h0000_8000);
    @(negedge clk);
    rd(5'd5, r); chk("R7 fast entry follows base", r, 32'h0000_8000);
    rd(5'd6, r); chk("R7 normal entry follows base", r, 32'h0000_8000);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule